// File: doc/BRIEF.md
# Serial Byte Receiver with Break Handling

This block receives 8n1 asynchronous serial frames on a single input line and hands each byte to a downstream consumer through a valid/ready stream. The line idles high. It passes through a two-flop synchronizer before it is sampled. A falling edge starts a frame, and the start bit is confirmed again at its midpoint. Each data bit is sampled at its centre, least significant bit first. The stop bit is sampled at its centre as well.

One select input chooses between two fixed bit rates, 115200 and 4,000,000 baud, from a 125 MHz clock. A fractional phase accumulator produces half-bit ticks. Because of this, the 4 Mbaud bit period (31.25 clocks) is correct on average. A bad stop bit produces one error pulse. The receiver then waits for the line to go high again, so a long break counts as a single error event.

A low glitch shorter than half a bit is treated as noise and is discarded. If a byte completes while the previous byte is still unaccepted, the new byte replaces it and an overflow pulse is raised.

Top module: `serial_rx_stream`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `overrun` and `frame_bad` are all 0.
- R2: With `fast_mode`=1 (4 Mbaud), a frame made of a low start bit, eight data bits sent LSB first, and a high stop bit delivers that byte on `out_data` with `out_valid`=1.
- R3: With `fast_mode`=0 (115200 baud), the same frame format sent at 1085 clocks per bit delivers the byte correctly.
- R4: Once `out_valid` is 1, it stays 1 and `out_data` stays unchanged until a clock edge at which `out_ready` is 1. `out_valid` then drops on the next cycle, unless a new byte arrives at that same edge.
- R5: A low pulse on the line shorter than half a bit period produces no byte and no `frame_bad` pulse, and the byte that follows is received correctly.
- R6: A frame whose stop bit samples low raises `frame_bad` for exactly one clock and delivers no byte.
- R7: A break (the line held low for many frame times) raises exactly one `frame_bad` pulse. After the line returns high, the next frame is received correctly.
- R8: If a byte completes while `out_valid`=1 and `out_ready`=0, `overrun` pulses for one clock and `out_data` takes the newer byte.
- R9: `frame_bad` and `overrun` are never high in the same cycle, and `overrun` is high only while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (125 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| fast_mode | input | 1 | 1 selects 4 Mbaud, 0 selects 115200 baud |
| out_ready | input | 1 | Consumer accepts the byte at this edge |
| out_valid | output | 1 | A received byte is waiting |
| out_data | output | 8 | Received byte |
| overrun | output | 1 | One-clock pulse: an unaccepted byte was overwritten |
| frame_bad | output | 1 | One-clock pulse: stop bit was low |

## Verification
Suppose the half-tick counter or the accumulator goes wrong. Then `out_data` carries bits shifted by a position, or a rate-dependent bit error, within one frame (about 300 clocks at the fast rate). A receiver that fails to wait for the line to rise after a bad stop bit shows up during a break as a second `frame_bad` pulse, about one frame time after the first. A broken hold on the stream side shows as `out_valid` falling, or `out_data` changing, while `out_ready` is low, on the cycle it happens.

// File: rtl/serial_rx_stream.sv
module serial_rx_stream #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int SLOW_BAUD = 115_200,
  parameter int FAST_BAUD = 4_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_line,
  input  logic       fast_mode,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       overrun,
  output logic       frame_bad
);
  localparam int ACC_W = $clog2(CLK_HZ + 2 * FAST_BAUD + 1);
  localparam logic [ACC_W-1:0] STEP_F = ACC_W'(2 * FAST_BAUD);
  localparam logic [ACC_W-1:0] STEP_S = ACC_W'(2 * SLOW_BAUD);
  localparam logic [ACC_W-1:0] WRAP   = ACC_W'(CLK_HZ);
  localparam logic [4:0]       LAST_H = 5'd18;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} state_t;

  logic [1:0]       sync;
  logic             line;
  state_t           state;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_sum;
  logic             tick;
  logic [4:0]       hcnt;
  logic [7:0]       shreg;

  assign line    = sync[1];
  assign acc_sum = acc + (fast_mode ? STEP_F : STEP_S);
  assign tick    = (state == S_RUN) && (acc_sum >= WRAP);

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rx_line};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      acc       <= '0;
      hcnt      <= '0;
      shreg     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      overrun   <= 1'b0;
      frame_bad <= 1'b0;
    end else begin
      overrun   <= 1'b0;
      frame_bad <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          acc  <= '0;
          hcnt <= '0;
          if (!line) state <= S_RUN;
        end
        S_RUN: begin
          acc <= tick ? acc_sum - WRAP : acc_sum;
          if (tick) begin
            hcnt <= hcnt + 5'd1;
            if (hcnt == 5'd0) begin
              if (line) state <= S_IDLE;
            end else if (hcnt == LAST_H) begin
              if (line) begin
                out_data  <= shreg;
                out_valid <= 1'b1;
                overrun   <= out_valid && !out_ready;
                state     <= S_IDLE;
              end else begin
                frame_bad <= 1'b1;
                state     <= S_HOLD;
              end
            end else if (!hcnt[0]) begin
              shreg <= {line, shreg[7:1]};
            end
          end
        end
        S_HOLD: if (line) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && !overrun && !frame_bad)); // R1

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && ($stable(out_data) || overrun))); // R4

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_bad |=> !frame_bad); // R7

  AST_OVR_PULSE: assert property (@(posedge clk) disable iff (rst)
    overrun |=> !overrun); // R8

  AST_ERR_NO_OVR: assert property (@(posedge clk) disable iff (rst)
    frame_bad |-> !overrun); // R9

  AST_OVR_HAS_BYTE: assert property (@(posedge clk) disable iff (rst)
    overrun |-> out_valid); // R9
endmodule

// File: tb/serial_rx_stream_test.sv
module serial_rx_stream_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       fast_mode = 1'b1;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       overrun;
  logic       frame_bad;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int fe_cnt = 0;
  int ov_cnt = 0;
  bit done = 0;

  localparam int FAST_BIT = 31;
  localparam int SLOW_BIT = 1085;

  localparam logic [8:0] VEC [6] = '{
    {1'b1, 8'hA5}, {1'b1, 8'h00}, {1'b1, 8'hFF},
    {1'b1, 8'h01}, {1'b1, 8'h80}, {1'b0, 8'h3C}
  };

  serial_rx_stream uut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .fast_mode(fast_mode),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .overrun(overrun), .frame_bad(frame_bad)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst && frame_bad) fe_cnt <= fe_cnt + 1;
    if (!rst && overrun) ov_cnt <= ov_cnt + 1;
    if (cyc > 190000 && !done) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 190000)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop, input int bitc);
    hold_line(1'b0, bitc);
    for (int i = 0; i < 8; i++) hold_line(b[i], bitc);
    hold_line(stop, bitc);
    rx_line = 1'b1;
  endtask

  task automatic wait_valid(input int lim, output bit seen);
    seen = 0;
    for (int i = 0; i < lim; i++) begin
      if (out_valid) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic accept();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    bit seen;
    int fe0;
    int ov0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !overrun && !frame_bad, "R1 during reset", {out_valid, overrun, frame_bad}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !overrun && !frame_bad, "R1 after reset", {out_valid, overrun, frame_bad}, 0);
    hold_line(1'b1, 40);

    for (int k = 0; k < 6; k++) begin
      fast_mode = VEC[k][8];
      send(VEC[k][7:0], 1'b1, fast_mode ? FAST_BIT : SLOW_BIT);
      wait_valid(200, seen);
      chk(seen && out_data == VEC[k][7:0], fast_mode ? "R2 fast byte" : "R3 slow byte",
          out_data, VEC[k][7:0]);
      accept();
      hold_line(1'b1, 20);
    end
    fast_mode = 1'b1;

    send(8'h96, 1'b1, FAST_BIT);
    wait_valid(200, seen);
    hold_line(1'b1, 50);
    chk(out_valid && out_data == 8'h96, "R4 held while not ready", out_data, 8'h96);
    accept();
    chk(!out_valid, "R4 cleared after ready", out_valid, 0);

    fe0 = fe_cnt;
    hold_line(1'b0, 8);
    hold_line(1'b1, 100);
    chk(!out_valid && fe_cnt == fe0, "R5 runt ignored", {out_valid, 8'(fe_cnt - fe0)}, 0);
    send(8'h5B, 1'b1, FAST_BIT);
    wait_valid(200, seen);
    chk(seen && out_data == 8'h5B, "R5 byte after runt", out_data, 8'h5B);
    accept();
    hold_line(1'b1, 20);

    fe0 = fe_cnt;
    send(8'h77, 1'b0, FAST_BIT);
    hold_line(1'b1, 100);
    chk(fe_cnt == fe0 + 1, "R6 one error for bad stop", fe_cnt - fe0, 1);
    chk(!out_valid, "R6 no byte on bad stop", out_valid, 0);

    fe0 = fe_cnt;
    hold_line(1'b0, 40 * FAST_BIT * 10);
    hold_line(1'b1, 100);
    chk(fe_cnt == fe0 + 1, "R7 break gives one error", fe_cnt - fe0, 1);
    chk(!out_valid, "R7 no byte from break", out_valid, 0);
    send(8'hC3, 1'b1, FAST_BIT);
    wait_valid(200, seen);
    chk(seen && out_data == 8'hC3, "R7 byte after break", out_data, 8'hC3);
    accept();
    hold_line(1'b1, 20);

    ov0 = ov_cnt;
    send(8'h11, 1'b1, FAST_BIT);
    hold_line(1'b1, 20);
    send(8'h22, 1'b1, FAST_BIT);
    hold_line(1'b1, 30);
    chk(ov_cnt == ov0 + 1, "R8 one overrun pulse", ov_cnt - ov0, 1);
    chk(out_valid && out_data == 8'h22, "R8 newer byte kept", out_data, 8'h22);
    accept();
    chk(!out_valid && !overrun, "R9 idle after accept", {out_valid, overrun}, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule